// File: doc/BRIEF.md
# Parallel ADC Read Controller

This block is the host side of a 12-bit successive-approximation converter that has a parallel data bus. When a start request arrives, it drives the converter's control pins to launch a conversion. It then polls the converter's busy status until the conversion is over and reads the result back. The result is presented as a 12-bit word with a one-cycle valid strobe. Every setup, hold, pulse-width and access interval on the control pins is counted in system clock cycles and set by parameters. The defaults suit a 100 MHz clock.

The read path has two modes, chosen by a width input that is latched with each start request. In full-width mode the controller reads all twelve data lines in a single strobe. In byte mode it performs two strobes with the byte-select pin low and then high, and joins the two left-justified bytes into the 12-bit result. The converter only drives its data lines while a particular combination of pin levels holds, so the controller takes a data sample only at the end of a counted access window inside that combination. If the converter never reports completion, a timeout ends the transaction with an error pulse, and no read is issued.

Top module: `adc_host_reader`

## Requirements
- R1: After reset and whenever no transaction is in flight, `busy_o`, `valid_o`, `err_o` and `conv_strobe_o` are low and `conv_sel_n_o` is high.
- R2: A conversion is launched with `conv_sel_n_o` low and `conv_rd_o` low for at least SETUP_CYC cycles before `conv_strobe_o` rises. The strobe then stays high for at least PULSE_CYC cycles, and select, read/convert and byte-select do not change while it is high.
- R3: After the conversion strobe, the controller waits at least STS_WAIT_CYC cycles before it accepts `conv_busy_i` low as completion. It never starts a read while the converter is still converting.
- R4: A read strobe follows at least SETUP_CYC cycles of stable select low, `conv_rd_o` high and byte-select. It stays high ACCESS_CYC cycles, and the data bus is sampled only in the last of those cycles, only while select is low, read/convert is high, the strobe is high and `conv_busy_i` is low.
- R5: After a read strobe falls, select and byte-select are held for at least FLOAT_CYC cycles before either of them changes.
- R6: With the width input high at start, exactly one read is made with byte-select low, `conv_wide_o` is high, and the result equals the 12 data lines.
- R7: With the width input low at start, two reads are made: first with byte-select 0, then with byte-select 1. The selected byte appears on data lines 11..4. The result is {first byte, upper nibble of second byte}, and data lines 3..0 are ignored.
- R8: `valid_o` is a single-cycle pulse that carries the result. `busy_o` is high from the cycle after an accepted start through the cycle of `valid_o` or `err_o`, and `valid_o` and `err_o` are never high together.
- R9: A start request while `busy_o` is high launches no extra conversion and produces no extra result.
- R10: If `conv_busy_i` has not returned low within TIMEOUT_CYC cycles after the conversion strobe, `err_o` pulses for one cycle, no read strobe is issued and the controller goes idle.
- R11: The width mode is captured at the accepted start request; changing `mode_wide_i` mid-transaction does not change the number of reads or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a conversion and read-back |
| mode_wide_i | input | 1 | 1: one 12-bit read, 0: two byte reads |
| result_o | output | 12 | Assembled conversion result |
| valid_o | output | 1 | One-cycle strobe, result_o valid |
| err_o | output | 1 | One-cycle strobe, completion timeout |
| busy_o | output | 1 | Transaction in flight |
| conv_sel_n_o | output | 1 | Converter chip select, active low |
| conv_strobe_o | output | 1 | Converter enable strobe, active high |
| conv_rd_o | output | 1 | 1: read, 0: convert |
| conv_bytesel_o | output | 1 | Byte select for byte-mode reads |
| conv_wide_o | output | 1 | Converter bus width pin, latched mode |
| conv_busy_i | input | 1 | Converter busy status |
| conv_data_i | input | 12 | Converter data bus |

## Verification
The hardest situation to reach is a status line that never falls, because a correct converter always finishes. The bench's converter model has a stuck knob that holds its status high after the strobe. The bench then waits out the full timeout and afterwards runs a normal transaction to show that the controller recovered. A mid-flight change of the width input and repeated start pulses during a conversion are driven on purpose. The model drives deliberate garbage whenever its enable combination is not met, and also during the early part of each access window, so any sample taken too early or outside the window yields a wrong result.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  localparam int RES_W  = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CV_SETUP,
    ST_CV_PULSE,
    ST_CV_WAIT,
    ST_RD_SETUP,
    ST_RD_ACCESS,
    ST_RD_FLOAT,
    ST_DONE,
    ST_FAIL
  } rd_state_e;

  typedef struct packed {
    logic sel_n;
    logic strobe;
    logic rd;
    logic bsel;
  } pin_set_t;

  // Pin levels are a pure decode of the phase and the byte index.
  function automatic pin_set_t pins_for(rd_state_e st, logic second);
    pin_set_t p;
    p.sel_n  = 1'b1;
    p.strobe = 1'b0;
    p.rd     = 1'b0;
    p.bsel   = 1'b0;
    case (st)
      ST_CV_SETUP:  p.sel_n = 1'b0;
      ST_CV_PULSE: begin
        p.sel_n  = 1'b0;
        p.strobe = 1'b1;
      end
      ST_RD_SETUP, ST_RD_ACCESS, ST_RD_FLOAT: begin
        p.sel_n  = 1'b0;
        p.rd     = 1'b1;
        p.bsel   = second;
        p.strobe = (st == ST_RD_ACCESS);
      end
      default: ;
    endcase
    return p;
  endfunction

  // Left-justified byte pair: high byte holds bits 11..4, the upper nibble
  // of the low byte holds bits 3..0.
  function automatic logic [RES_W-1:0] join_bytes(logic [BYTE_W-1:0] hi,
                                                  logic [3:0] lo);
    return {hi, lo};
  endfunction

  // Elapsed cycles in the wait phase, given the down-counter remainder.
  function automatic logic sts_window_open(int unsigned rem,
                                           int unsigned total,
                                           int unsigned gap);
    return ((total - 1 - rem) >= gap);
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcrd_timer.sv
module adcrd_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign count_o = cnt_q;
  assign zero_o  = (cnt_q == '0);

  // Phase counts step down by exactly one per cycle (timing basis of R2/R4/R5).
  assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adcrd_assemble.sv
module adcrd_assemble
  import adcrd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic             wide_i,
  input  logic             second_i,
  input  logic [RES_W-1:0] data_i,
  output logic [RES_W-1:0] result_o
);

  logic [BYTE_W-1:0] hi_q;
  logic [RES_W-1:0]  res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      res_q <= '0;
    end else if (capture_i) begin
      if (wide_i)         res_q <= data_i;
      else if (!second_i) hi_q  <= data_i[RES_W-1 -: BYTE_W];
      else                res_q <= join_bytes(hi_q, data_i[RES_W-1 -: 4]);
    end
  end

  assign result_o = res_q;

  assert_wide_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && wide_i) |=> (result_o == $past(data_i)));

  assert_byte_join_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && !wide_i && second_i) |=>
      (result_o[3:0] == $past(data_i[RES_W-1 -: 4])));

endmodule

// File: rtl/adc_host_reader.sv
module adc_host_reader
  import adcrd_pkg::*;
#(
  parameter int SETUP_CYC    = 5,
  parameter int PULSE_CYC    = 5,
  parameter int ACCESS_CYC   = 15,
  parameter int FLOAT_CYC    = 15,
  parameter int STS_WAIT_CYC = 20,
  parameter int TIMEOUT_CYC  = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_wide_i,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic             err_o,
  output logic             busy_o,
  output logic             conv_sel_n_o,
  output logic             conv_strobe_o,
  output logic             conv_rd_o,
  output logic             conv_bytesel_o,
  output logic             conv_wide_o,
  input  logic             conv_busy_i,
  input  logic [RES_W-1:0] conv_data_i
);

  localparam int MAX_CYC = max_of(max_of(max_of(SETUP_CYC, PULSE_CYC),
                                         max_of(ACCESS_CYC, FLOAT_CYC)),
                                  TIMEOUT_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LV_SETUP  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LV_PULSE  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LV_ACCESS = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] LV_FLOAT  = CNT_W'(FLOAT_CYC - 1);
  localparam logic [CNT_W-1:0] LV_TOUT   = CNT_W'(TIMEOUT_CYC - 1);

  rd_state_e        state_q, state_d;
  logic             mode_q;
  logic             byte_q;
  logic             set_byte;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_zero;
  logic             win_open;
  logic             sample_w;
  logic             accept_w;
  pin_set_t         pins;

  adcrd_timer #(.W(CNT_W)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .count_o    (tmr_cnt),
    .zero_o     (tmr_zero)
  );

  assign win_open = sts_window_open(32'(tmr_cnt), TIMEOUT_CYC, STS_WAIT_CYC);
  assign accept_w = (state_q == ST_IDLE) && start_i;
  assign sample_w = (state_q == ST_RD_ACCESS) && tmr_zero;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    set_byte = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_CV_SETUP; tmr_load = 1'b1; tmr_val = LV_SETUP;
      end
      ST_CV_SETUP: if (tmr_zero) begin
        state_d = ST_CV_PULSE; tmr_load = 1'b1; tmr_val = LV_PULSE;
      end
      ST_CV_PULSE: if (tmr_zero) begin
        state_d = ST_CV_WAIT; tmr_load = 1'b1; tmr_val = LV_TOUT;
      end
      ST_CV_WAIT: begin
        if (win_open && !conv_busy_i) begin
          state_d = ST_RD_SETUP; tmr_load = 1'b1; tmr_val = LV_SETUP;
        end else if (tmr_zero) begin
          state_d = ST_FAIL;
        end
      end
      ST_RD_SETUP: if (tmr_zero) begin
        state_d = ST_RD_ACCESS; tmr_load = 1'b1; tmr_val = LV_ACCESS;
      end
      ST_RD_ACCESS: if (tmr_zero) begin
        state_d = ST_RD_FLOAT; tmr_load = 1'b1; tmr_val = LV_FLOAT;
      end
      ST_RD_FLOAT: if (tmr_zero) begin
        if (!mode_q && !byte_q) begin
          state_d = ST_RD_SETUP; tmr_load = 1'b1; tmr_val = LV_SETUP;
          set_byte = 1'b1;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      ST_FAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b1;
      byte_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_w) begin
        mode_q <= mode_wide_i;
        byte_q <= 1'b0;
      end else if (set_byte) begin
        byte_q <= 1'b1;
      end
    end
  end

  adcrd_assemble asm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (sample_w),
    .wide_i    (mode_q),
    .second_i  (byte_q),
    .data_i    (conv_data_i),
    .result_o  (result_o)
  );

  assign pins           = pins_for(state_q, byte_q);
  assign conv_sel_n_o   = pins.sel_n;
  assign conv_strobe_o  = pins.strobe;
  assign conv_rd_o      = pins.rd;
  assign conv_bytesel_o = pins.bsel;
  assign conv_wide_o    = mode_q;
  assign busy_o         = (state_q != ST_IDLE);
  assign valid_o        = (state_q == ST_DONE);
  assign err_o          = (state_q == ST_FAIL);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!conv_strobe_o && conv_sel_n_o && !valid_o && !err_o));

  assert_pins_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe_o && $past(conv_strobe_o)) |->
      ($stable(conv_sel_n_o) && $stable(conv_rd_o) && $stable(conv_bytesel_o)));

  assert_read_after_idle_sts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_SETUP && $past(state_q) == ST_CV_WAIT) |-> !$past(conv_busy_i));

  assert_sample_bus_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_w |-> (conv_strobe_o && conv_rd_o && !conv_sel_n_o && !conv_busy_i));

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_valid_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));

  assert_err_from_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($past(state_q) == ST_CV_WAIT && !conv_strobe_o));

  assert_mode_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mode_q));

endmodule

// File: tb/adc_host_reader_tb_top.sv
`timescale 1ns/1ps
module adc_host_reader_tb_top;

  localparam int SETUP  = 5;
  localparam int PULSE  = 5;
  localparam int ACCESS = 15;
  localparam int FLOAT  = 15;
  localparam int STSW   = 20;
  localparam int TOUT   = 3000;
  localparam int CONV   = 50;
  localparam int LIVE_AFTER = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start_i, mode_wide_i;
  logic [11:0] result_o;
  logic        valid_o, err_o, busy_o;
  logic        sel_n, strobe, rd, bsel, wide_pin;
  logic        sts;
  logic [11:0] data;

  adc_host_reader #(
    .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .ACCESS_CYC(ACCESS),
    .FLOAT_CYC(FLOAT), .STS_WAIT_CYC(STSW), .TIMEOUT_CYC(TOUT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_wide_i(mode_wide_i),
    .result_o(result_o), .valid_o(valid_o), .err_o(err_o), .busy_o(busy_o),
    .conv_sel_n_o(sel_n), .conv_strobe_o(strobe), .conv_rd_o(rd),
    .conv_bytesel_o(bsel), .conv_wide_o(wide_pin),
    .conv_busy_i(sts), .conv_data_i(data)
  );

  // ---------------- converter model ----------------
  bit          stuck = 0;
  bit          converting = 0;
  int          conv_cnt = 0;
  int          conv_starts = 0;
  int          reads = 0;
  int          ce_hi_cnt = 0;
  logic        ce_prev = 1'b0;
  logic [11:0] next_val = '0;
  logic [11:0] conv_val = '0;
  bit          a0_q[$];
  logic        bus_live;
  logic [11:0] payload;

  assign bus_live = rd && !sts && strobe && !sel_n && (ce_hi_cnt >= LIVE_AFTER);
  assign payload  = wide_pin ? conv_val :
                    (bsel ? {conv_val[3:0], 4'b0000, 4'h9} : {conv_val[11:4], 4'h9});
  assign data     = bus_live ? payload : 12'h5A5;

  // port-level timing monitor state
  logic [2:0] pins_prev = 3'b100;
  int  stable_cnt = 0, hi_cnt = 0, fall_cnt = 0;
  bit  last_was_read = 0, rise_rd = 0;
  int  err_r2 = 0, err_r3 = 0, err_r4 = 0, err_r5 = 0;
  bit  mbusy = 0;

  always @(posedge clk) begin
    logic [2:0] cur;
    if (!rst_n) begin
      converting = 0; sts <= 1'b0; ce_hi_cnt <= 0; mbusy = 0;
      stable_cnt = 0; hi_cnt = 0; fall_cnt = 0; ce_prev = 1'b0;
      pins_prev = {sel_n, rd, bsel};
    end else begin
      // reference busy model (R8, R9)
      if (valid_o || err_o)        mbusy = 0;
      else if (start_i && !mbusy)  mbusy = 1;
      // converter behaviour
      if (strobe && !ce_prev && !sel_n && !rd) begin
        converting = 1; conv_cnt = 0; conv_val <= next_val; conv_starts++;
      end
      if (strobe && !ce_prev && !sel_n && rd) begin
        reads++; a0_q.push_back(bsel);
        if (converting) err_r3++;
      end
      if (converting) begin
        conv_cnt++;
        if (conv_cnt == 3) sts <= 1'b1;
        if (conv_cnt >= 3 + CONV && !stuck) begin converting = 0; sts <= 1'b0; end
      end
      ce_hi_cnt <= strobe ? ce_hi_cnt + 1 : 0;
      // timing monitor
      cur = {sel_n, rd, bsel};
      if (strobe && !ce_prev) begin
        rise_rd = rd;
        if (stable_cnt < SETUP) begin
          if (rd) err_r4++; else err_r2++;
        end
      end
      if (cur != pins_prev) begin
        if (strobe) err_r2++;
        if (!strobe && last_was_read && fall_cnt < FLOAT) err_r5++;
        stable_cnt = 1;
        last_was_read = 0;
      end else begin
        stable_cnt++;
      end
      if (strobe) hi_cnt++;
      else if (ce_prev) begin
        if (rise_rd && hi_cnt != ACCESS) err_r4++;
        if (!rise_rd && hi_cnt < PULSE) err_r2++;
        hi_cnt = 0; fall_cnt = 1; last_was_read = rise_rd;
      end else fall_cnt++;
      pins_prev = cur;
      ce_prev = strobe;
    end
  end

  // ---------------- per-clock reference compare ----------------
  int          ref_checks = 0, ref_fail = 0, valid_total = 0, err_total = 0;
  logic [11:0] exp_val = '0;
  bit          exp_err = 0;
  bit          valid_prev = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      ref_checks++;
      if (busy_o !== mbusy) begin
        ref_fail++;
        $display("FAIL R8 busy actual=%0d expected=%0d", busy_o, mbusy);
      end
      if (valid_o) begin
        valid_total++; ref_checks++;
        if (result_o !== exp_val || exp_err) begin
          ref_fail++;
          $display("FAIL R8 result actual=%03h expected=%03h", result_o, exp_val);
        end
      end
      if (valid_o && valid_prev) begin
        ref_fail++;
        $display("FAIL R8 valid width actual=2 expected=1");
      end
      if (err_o) begin
        err_total++;
        if (!exp_err) begin
          ref_fail++;
          $display("FAIL R10 err actual=1 expected=0");
        end
      end
      valid_prev = valid_o;
    end
  end

  // ---------------- stimulus ----------------
  int checks = 0, failures = 0;
  bit timed_out = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!(valid_o || err_o) && n < 6000) begin @(negedge clk); n++; end
  endtask

  task automatic run_one(input logic [11:0] v, input logic wide, input bool_flip,
                         output int nreads);
    int r0 = reads;
    a0_q.delete();
    next_val = v; exp_val = v;
    @(negedge clk); mode_wide_i = wide; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (bool_flip) mode_wide_i = ~wide;
    wait_done();
    nreads = reads - r0;
  endtask

  task automatic tests();
    int nr, c0, v0;
    logic [11:0] wv[3];
    logic [11:0] bv[4];
    wv[0] = 12'hABC; wv[1] = 12'h000; wv[2] = 12'hFFF;
    bv[0] = 12'h5A3; bv[1] = 12'hFFF; bv[2] = 12'h001; bv[3] = 12'h80F;

    rst_n = 1'b0; start_i = 1'b0; mode_wide_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !valid_o && !err_o && !strobe && sel_n, "R1 reset idle",
        {busy_o, valid_o, err_o, strobe, sel_n}, 5'b00001);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && sel_n && !strobe, "R1 idle after reset", {busy_o, sel_n, strobe}, 3'b010);

    foreach (wv[i]) begin
      run_one(wv[i], 1'b1, 1'b0, nr);
      chk(valid_o && result_o == wv[i], "R6 wide result", result_o, wv[i]);
      chk(nr == 1 && a0_q.size() == 1 && a0_q[0] == 1'b0 && wide_pin,
          "R6 one read bytesel 0", nr, 1);
      @(negedge clk);
    end

    foreach (bv[i]) begin
      run_one(bv[i], 1'b0, 1'b0, nr);
      chk(valid_o && result_o == bv[i], "R7 byte result", result_o, bv[i]);
      chk(nr == 2 && a0_q.size() == 2 && a0_q[0] == 1'b0 && a0_q[1] == 1'b1,
          "R7 two reads bytesel 0 then 1", nr, 2);
      @(negedge clk);
    end

    // R9: extra starts during a conversion
    c0 = conv_starts; v0 = valid_total;
    next_val = 12'h3C7; exp_val = 12'h3C7;
    @(negedge clk); mode_wide_i = 1'b1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (8) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (30) @(negedge clk);
    start_i = 1'b1; repeat (3) @(negedge clk); start_i = 1'b0;
    wait_done();
    chk(valid_o && result_o == 12'h3C7, "R9 result while restarted", result_o, 12'h3C7);
    repeat (300) @(negedge clk);
    chk(conv_starts - c0 == 1, "R9 one conversion", conv_starts - c0, 1);
    chk(valid_total - v0 == 1 && !busy_o, "R9 one result", valid_total - v0, 1);

    // R11: mode flips after acceptance
    run_one(12'h6E2, 1'b0, 1'b1, nr);
    chk(valid_o && result_o == 12'h6E2 && nr == 2, "R11 byte mode kept", nr, 2);
    @(negedge clk);
    run_one(12'h19D, 1'b1, 1'b1, nr);
    chk(valid_o && result_o == 12'h19D && nr == 1, "R11 wide mode kept", nr, 1);
    @(negedge clk);

    // R10: status never falls
    stuck = 1; exp_err = 1;
    c0 = err_total;
    run_one(12'h777, 1'b1, 1'b0, nr);
    chk(err_o && !valid_o, "R10 err pulse", err_o, 1);
    chk(nr == 0, "R10 no read strobe", nr, 0);
    @(negedge clk);
    chk(!busy_o && !err_o && err_total - c0 == 1, "R10 back to idle", busy_o, 0);
    stuck = 0;
    repeat (20) @(negedge clk);
    exp_err = 0;
    run_one(12'hC05, 1'b0, 1'b0, nr);
    chk(valid_o && result_o == 12'hC05, "R10 recovery read", result_o, 12'hC05);
    repeat (5) @(negedge clk);

    chk(err_r2 == 0, "R2 convert setup and pulse", err_r2, 0);
    chk(err_r3 == 0, "R3 read only after conversion", err_r3, 0);
    chk(err_r4 == 0, "R4 read setup and access", err_r4, 0);
    chk(err_r5 == 0, "R5 float hold", err_r5, 0);
  endtask

  initial begin
    fork
      tests();
      begin repeat (150000) @(posedge clk); timed_out = 1; end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    checks   += ref_checks;
    failures += ref_fail;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule